// File: doc/BRIEF.md
# PCI Target Termination Sequencer

This block is the target-side bus sequencer of a PCI interface. It watches the active-low FRAME# and IRDY# lines, decides from an address-decode hit and the operating mode whether to claim a new transaction, drives DEVSEL#, TRDY# and STOP#, and chooses how each transaction ends. A transaction can end in four ways: normal completion, disconnect with data, retry, or target-abort. The back end supplies a data-ready strobe, a stop request, a corrupt-read flag and two parity-error flags. The block returns a one-cycle internal abort pulse when a parity error is absorbed without disturbing the bus.

Mode inputs choose host or agent operation and a configuration lock. A first-data latency timer turns a slow start into a retry and can be switched off. Fast back-to-back transactions are always accepted. When the block was not the previous target, it delays its response by one clock.

All inputs are sampled on the rising clock edge. All outputs are registered. "Edge E0" below is the edge that first samples FRAME# low after it was high.

Top module: `pci_tgt_term`

## Requirements
- R1: While reset is held and on the first edge after it, DEVSEL#, TRDY# and STOP# are high (released) and `int_abort` is low.
- R2: For a claimed transaction with no back-to-back delay, DEVSEL# goes low after edge E0+1. TRDY# goes low no earlier than the next edge, at the first data-state edge that samples `data_ready` high. TRDY# is never low while DEVSEL# is high.
- R3: A data phase completes at an edge that samples IRDY# and TRDY# both low. If FRAME# is high at that edge, all three outputs are released after it.
- R4: With `host_mode`=1, an access with `cfg_space`=1 is never claimed: DEVSEL# stays high for the whole transaction.
- R5: With `host_mode`=0, `cfg_lock`=1 and `cfg_space`=1, the block drives DEVSEL# and STOP# low together after E0+1. TRDY# is never asserted (retry).
- R6: When `stop_req` and `data_ready` are both high at the edge that asserts TRDY#, STOP# goes low in the same cycle. After that phase completes, TRDY# returns high and STOP# stays low.
- R7: While STOP# is low and FRAME# is sampled low, STOP# stays low. At the first edge that samples FRAME# high, all outputs are released.
- R8: In a read data state, `data_ready` with `rd_corrupt` high causes a target-abort after that edge: DEVSEL# high and STOP# low. DEVSEL# has been low for at least the preceding cycle.
- R9: An address parity error sampled at E0 of a claimed transaction, or a data parity error at a completed write data phase, produces a one-cycle `int_abort` pulse after that edge. The bus sequence is unchanged and no target-abort occurs.
- R10: When FRAME# is sampled low right after an edge that sampled IRDY# low and FRAME# high, and DEVSEL# was high in the cycle before the address phase, DEVSEL# and TRDY# come one edge later (DEVSEL# after E0+2).
- R11: A back-to-back transaction that follows one this block claimed itself gets no extra delay (DEVSEL# after E0+1).
- R12: With `lat_en`=1, if no data phase has completed or started by edge E0+16 (LAT_CLKS) and `data_ready` is low there, STOP# goes low after that edge with TRDY# high (retry).
- R13: With `lat_en`=0, the late-data retry never happens: STOP# stays high, and TRDY# asserts whenever data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| addr_hit | input | 1 | Address decodes to this target (valid at E0) |
| cfg_space | input | 1 | Access targets configuration or internal register space (valid at E0) |
| cmd_read | input | 1 | 1 = read command (valid at E0) |
| host_mode | input | 1 | 1 = host operation, 0 = agent operation |
| cfg_lock | input | 1 | Configuration lock |
| lat_en | input | 1 | Enables the first-data latency timer |
| data_ready | input | 1 | Back end can move a data phase |
| stop_req | input | 1 | Back end wants this to be the last data phase |
| rd_corrupt | input | 1 | Read data from the back end is corrupt |
| addr_perr | input | 1 | Address parity error (valid at E0) |
| data_perr | input | 1 | Data parity error on the current write phase |
| devsel_n | output | 1 | DEVSEL#, active low |
| trdy_n | output | 1 | TRDY#, active low |
| stop_n | output | 1 | STOP#, active low |
| int_abort | output | 1 | One-cycle internal abort pulse |

## Verification
Every result is due at a fixed edge offset from E0. DEVSEL# is due after E0+1, or E0+2 when delayed. TRDY# is due one edge after DEVSEL#, and the lock retry comes together with DEVSEL#. The target-abort comes at the first data-state edge. The latency retry comes after E0+16, and release comes at the edge that samples FRAME# high. Parity pulses last exactly the one cycle after the edge where the error is sampled. The driver computes each of these edge numbers from E0 as it starts a transaction, and queues the expected pin values under them. The monitor samples on the falling edge and compares only entries whose edge number equals the count of rising edges seen so far.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_DEC,
    ST_DATA,
    ST_TERM
  } tgt_state_e;
endpackage

// File: rtl/pci_tgt_claim.sv
module pci_tgt_claim (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic devsel_n,
  input  logic addr_hit,
  input  logic cfg_space,
  input  logic host_mode,
  input  logic cfg_lock,
  output logic start,
  output logic claim,
  output logic lock_retry,
  output logic b2b_delay
);
  logic frame_q, irdy_q, dsl_q;

  // bus history one edge back, used for start and back-to-back detection
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b1;
      irdy_q  <= 1'b1;
      dsl_q   <= 1'b1;
    end else begin
      frame_q <= frame_n;
      irdy_q  <= irdy_n;
      dsl_q   <= devsel_n;
    end
  end

  assign start      = !frame_n && frame_q;
  assign claim      = addr_hit && !(host_mode && cfg_space);   // R4
  assign lock_retry = !host_mode && cfg_lock && cfg_space;     // R5
  assign b2b_delay  = !irdy_q && dsl_q;                        // R10 R11
endmodule

// File: rtl/pci_tgt_lat_timer.sv
module pci_tgt_lat_timer #(
  parameter int LAT_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LAT_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LAT_CLKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (accept)              cnt <= CW'(1);
    else if (run && cnt != LIMIT) cnt <= cnt + CW'(1);
  end

  assign expired = (cnt == LIMIT);

  AST_LAT_FRESH: assert property (@(posedge clk) disable iff (rst)
    accept |=> !expired); // R12
endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
  import pci_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic claim,
  input  logic lock_retry,
  input  logic b2b_delay,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic cmd_read,
  input  logic data_ready,
  input  logic stop_req,
  input  logic rd_corrupt,
  input  logic addr_perr,
  input  logic data_perr,
  input  logic lat_en,
  input  logic lat_expired,
  output logic accept,
  output logic timer_run,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic int_abort
);
  tgt_state_e st;
  logic rd_q, lock_q, fd_q;
  logic xfer, abort_now, late_now;

  assign accept    = (st == ST_IDLE) && start && claim;
  assign timer_run = (st != ST_IDLE) && !fd_q;
  assign xfer      = !trdy_n && !irdy_n;
  assign abort_now = rd_q && data_ready && rd_corrupt;                 // R8
  assign late_now  = lat_en && lat_expired && !fd_q && !xfer;          // R12 R13

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      devsel_n  <= 1'b1;
      trdy_n    <= 1'b1;
      stop_n    <= 1'b1;
      int_abort <= 1'b0;
      rd_q      <= 1'b0;
      lock_q    <= 1'b0;
      fd_q      <= 1'b0;
    end else begin
      int_abort <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            rd_q      <= cmd_read;
            lock_q    <= lock_retry;
            fd_q      <= 1'b0;
            int_abort <= addr_perr;                                    // R9
            st        <= b2b_delay ? ST_HOLD : ST_DEC;                 // R10
          end
        end
        ST_HOLD: st <= ST_DEC;
        ST_DEC: begin
          devsel_n <= 1'b0;                                            // R2
          if (lock_q) begin
            stop_n <= 1'b0;                                            // R5
            st     <= ST_TERM;
          end else begin
            st <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (xfer) begin
            fd_q <= 1'b1;
            if (!rd_q && data_perr) int_abort <= 1'b1;                 // R9
          end
          if (xfer && frame_n) begin                                   // R3
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
            st       <= ST_IDLE;
          end else if (xfer && !stop_n) begin                          // R6
            trdy_n <= 1'b1;
            st     <= ST_TERM;
          end else if (!trdy_n && !xfer) begin
            trdy_n <= 1'b0;
          end else if (abort_now) begin
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b0;
            st       <= ST_TERM;
          end else if (data_ready) begin
            trdy_n <= 1'b0;
            stop_n <= !stop_req;
          end else if (late_now) begin
            trdy_n <= 1'b1;
            stop_n <= 1'b0;
            st     <= ST_TERM;
          end else begin
            trdy_n <= 1'b1;
          end
        end
        ST_TERM: begin
          if (frame_n) begin                                           // R7
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_TRDY_NEEDS_DEVSEL: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !devsel_n); // R2
  AST_STOP_HELD: assert property (@(posedge clk) disable iff (rst)
    (!stop_n && !frame_n) |=> !stop_n); // R7
  AST_ABORT_AFTER_DEVSEL: assert property (@(posedge clk) disable iff (rst)
    (!stop_n && devsel_n && $past(stop_n)) |-> !$past(devsel_n)); // R8
  AST_PERR_NO_TABORT: assert property (@(posedge clk) disable iff (rst)
    int_abort |-> !(devsel_n && !stop_n)); // R9
endmodule

// File: rtl/pci_tgt_term.sv
module pci_tgt_term #(
  parameter int LAT_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic addr_hit,
  input  logic cfg_space,
  input  logic cmd_read,
  input  logic host_mode,
  input  logic cfg_lock,
  input  logic lat_en,
  input  logic data_ready,
  input  logic stop_req,
  input  logic rd_corrupt,
  input  logic addr_perr,
  input  logic data_perr,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic int_abort
);
  logic start, claim, lock_retry, b2b_delay;
  logic accept, timer_run, lat_expired;

  pci_tgt_claim u_claim (
    .clk        (clk),
    .rst        (rst),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .devsel_n   (devsel_n),
    .addr_hit   (addr_hit),
    .cfg_space  (cfg_space),
    .host_mode  (host_mode),
    .cfg_lock   (cfg_lock),
    .start      (start),
    .claim      (claim),
    .lock_retry (lock_retry),
    .b2b_delay  (b2b_delay)
  );

  pci_tgt_lat_timer #(.LAT_CLKS(LAT_CLKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .run     (timer_run),
    .expired (lat_expired)
  );

  pci_tgt_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .claim       (claim),
    .lock_retry  (lock_retry),
    .b2b_delay   (b2b_delay),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .cmd_read    (cmd_read),
    .data_ready  (data_ready),
    .stop_req    (stop_req),
    .rd_corrupt  (rd_corrupt),
    .addr_perr   (addr_perr),
    .data_perr   (data_perr),
    .lat_en      (lat_en),
    .lat_expired (lat_expired),
    .accept      (accept),
    .timer_run   (timer_run),
    .devsel_n    (devsel_n),
    .trdy_n      (trdy_n),
    .stop_n      (stop_n),
    .int_abort   (int_abort)
  );
endmodule

// File: tb/pci_tgt_term_tb_top.sv
module pci_tgt_term_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1, addr_hit = 1'b0, cfg_space = 1'b0;
  logic cmd_read = 1'b1, host_mode = 1'b0, cfg_lock = 1'b0, lat_en = 1'b1;
  logic data_ready = 1'b1, stop_req = 1'b0, rd_corrupt = 1'b0;
  logic addr_perr = 1'b0, data_perr = 1'b0;
  logic devsel_n, trdy_n, stop_n, int_abort;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected pins: {devsel_n, trdy_n, stop_n, int_abort}
  typedef struct {
    int         en;
    logic [3:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];
  exp_t it;

  always #4 clk = ~clk;

  pci_tgt_term dut_i (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
    .addr_hit(addr_hit), .cfg_space(cfg_space), .cmd_read(cmd_read),
    .host_mode(host_mode), .cfg_lock(cfg_lock), .lat_en(lat_en),
    .data_ready(data_ready), .stop_req(stop_req), .rd_corrupt(rd_corrupt),
    .addr_perr(addr_perr), .data_perr(data_perr),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .int_abort(int_abort)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations at the edge they are due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].en <= cyc) begin
      it = q.pop_front();
      checks++;
      if (it.en != cyc || {devsel_n, trdy_n, stop_n, int_abort} != it.v) begin
        errors++;
        $display("FAIL %s edge %0d actual %b expected %b", it.tag, it.en,
                 {devsel_n, trdy_n, stop_n, int_abort}, it.v);
      end
    end
  end

  task automatic push(int en, logic [3:0] v, string tag);
    exp_t e;
    e.en = en; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic at(int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b1; addr_hit = 1'b0;
    end
  endtask

  task automatic start_txn(output int e0);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; addr_hit = 1'b1;
    e0 = cyc + 1;
  endtask

  task automatic normal_txn(bit rd, bit ap, bit dp, int dl, string dtag);
    int e0;
    cmd_read = rd; addr_perr = ap; data_ready = 1'b1;
    start_txn(e0);
    push(e0, {3'b111, ap}, "R9");
    if (dl != 0) push(e0 + 1, 4'b1110, "R10");
    push(e0 + 1 + dl, 4'b0110, dtag);
    push(e0 + 2 + dl, 4'b0010, "R2");
    push(e0 + 3 + dl, {3'b001, dp && !rd}, "R9");
    push(e0 + 4 + dl, 4'b1110, "R3");
    at(e0); irdy_n = 1'b0; addr_perr = 1'b0;
    at(e0 + 2 + dl); data_perr = dp;
    at(e0 + 3 + dl); data_perr = 1'b0; frame_n = 1'b1;
  endtask

  task automatic foreign_txn();
    @(negedge clk); frame_n = 1'b0; irdy_n = 1'b1; addr_hit = 1'b0;
    @(negedge clk); frame_n = 1'b1; irdy_n = 1'b0;
  endtask

  task automatic host_cfg();
    int e0;
    host_mode = 1'b1; cfg_space = 1'b1;
    start_txn(e0);
    push(e0 + 1, 4'b1110, "R4");
    push(e0 + 2, 4'b1110, "R4");
    push(e0 + 3, 4'b1110, "R4");
    at(e0); irdy_n = 1'b0;
    at(e0 + 1); frame_n = 1'b1;
    at(e0 + 2); irdy_n = 1'b1; host_mode = 1'b0; cfg_space = 1'b0;
  endtask

  task automatic lock_retry();
    int e0;
    cfg_lock = 1'b1; cfg_space = 1'b1;
    start_txn(e0);
    push(e0 + 1, 4'b0100, "R5");
    push(e0 + 2, 4'b1110, "R7");
    at(e0); irdy_n = 1'b0;
    at(e0 + 1); frame_n = 1'b1;
    at(e0 + 2); irdy_n = 1'b1; cfg_lock = 1'b0; cfg_space = 1'b0;
  endtask

  task automatic disconnect();
    int e0;
    cmd_read = 1'b1; stop_req = 1'b1;
    start_txn(e0);
    push(e0 + 1, 4'b0110, "R2");
    push(e0 + 2, 4'b0000, "R6");
    push(e0 + 3, 4'b0100, "R6");
    push(e0 + 4, 4'b1110, "R7");
    at(e0); irdy_n = 1'b0;
    at(e0 + 3); frame_n = 1'b1;
    at(e0 + 4); irdy_n = 1'b1; stop_req = 1'b0;
  endtask

  task automatic tabort();
    int e0;
    cmd_read = 1'b1; rd_corrupt = 1'b1;
    start_txn(e0);
    push(e0 + 1, 4'b0110, "R8");
    push(e0 + 2, 4'b1100, "R8");
    push(e0 + 3, 4'b1110, "R7");
    at(e0); irdy_n = 1'b0;
    at(e0 + 2); frame_n = 1'b1;
    at(e0 + 3); irdy_n = 1'b1; rd_corrupt = 1'b0;
  endtask

  task automatic late_data(bit en);
    int e0;
    lat_en = en; data_ready = 1'b0;
    start_txn(e0);
    push(e0 + 1, 4'b0110, "R2");
    push(e0 + 15, 4'b0110, en ? "R12" : "R13");
    if (en) begin
      push(e0 + 16, 4'b0100, "R12");
      push(e0 + 17, 4'b1110, "R7");
      at(e0); irdy_n = 1'b0;
      at(e0 + 16); frame_n = 1'b1;
      at(e0 + 17); irdy_n = 1'b1;
    end else begin
      push(e0 + 16, 4'b0110, "R13");
      push(e0 + 17, 4'b0110, "R13");
      push(e0 + 20, 4'b0010, "R13");
      push(e0 + 21, 4'b1110, "R3");
      at(e0); irdy_n = 1'b0;
      at(e0 + 19); data_ready = 1'b1;
      at(e0 + 20); frame_n = 1'b1;
      at(e0 + 21); irdy_n = 1'b1;
    end
    data_ready = 1'b1; lat_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    push(cyc + 1, 4'b1110, "R1");
    @(negedge clk);
    rst = 1'b0;
    push(cyc + 1, 4'b1110, "R1");
    idle(3);
    normal_txn(1'b1, 1'b0, 1'b0, 0, "R2");
    idle(2);
    normal_txn(1'b0, 1'b1, 1'b1, 0, "R2");
    normal_txn(1'b1, 1'b0, 1'b0, 0, "R11");
    idle(2);
    foreign_txn();
    normal_txn(1'b1, 1'b0, 1'b0, 1, "R10");
    idle(2);
    host_cfg();
    idle(2);
    lock_retry();
    idle(2);
    disconnect();
    idle(2);
    tabort();
    idle(2);
    late_data(1'b1);
    idle(2);
    late_data(1'b0);
    idle(4);
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule